// File: doc/BRIEF.md
# Pause-Width Reader Frame Encoder

This block sends a reader-to-tag command frame by switching a carrier-enable line. Every bit opens with a fixed carrier-off gap of `PAUSE_CYC` clock cycles. The carrier then comes back on, and the bit value sets how long the whole bit lasts. A one-bit lasts `ONE_CYC` cycles and a zero-bit lasts `ZERO_CYC` cycles. Both lengths are measured from the first gap cycle. After the last data bit, one more gap of the same length closes the frame, and the carrier is then switched on again.

A one-cycle start strobe loads a data word and a bit count, and the frame follows at once. While the frame is running, the block reports busy. When the frame ends, it raises a one-cycle done pulse and restarts a free-running elapsed-time counter. Receive logic can use this counter to measure the tag's reply window from the end of the frame. Between frames the carrier is held on, so the tag stays powered.

Top module: `rdr_pause_encoder`

## Requirements
- R1: Every data bit begins with exactly `PAUSE_CYC` consecutive cycles of `carrier_o` = 0. `PAUSE_CYC` is smaller than both bit periods.
- R2: After its gap, a bit keeps `carrier_o` = 1 until its period ends. The total period is `ONE_CYC` cycles for a 1 and `ZERO_CYC` cycles for a 0.
- R3: Bits go out least significant first: bit i of the frame is `data_i[i]`.
- R4: After the last data bit, `carrier_o` is 0 for exactly `PAUSE_CYC` more cycles and then returns to 1.
- R5: A bit count of 0 sends only the closing gap. A bit count above `MAX_BITS` (16) is treated as `MAX_BITS`.
- R6: A start strobe that arrives while `busy_o` = 1 is ignored, and the frame in progress continues unchanged.
- R7: A strobe accepted at a clock edge makes the following cycle the first gap cycle of the frame. `busy_o` is 1 from that cycle through the last closing-gap cycle. While idle, `carrier_o` = 1.
- R8: `done_o` is 1 for exactly one cycle: the cycle right after the closing gap, when `busy_o` is already 0 and `carrier_o` is 1.
- R9: `since_end_o` reads 0 in the done cycle and rises by one each cycle after that. It holds at all ones.
- R10: After reset, `carrier_o` = 1, `busy_o` = 0, `done_o` = 0 and `since_end_o` = all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| data_i | input | MAX_BITS | Frame data, sent LSB first |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of data bits |
| carrier_o | output | 1 | Carrier enable, 0 during gaps |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| since_end_o | output | REF_W | Cycles since the last frame end, saturating |

## Verification
An accepted strobe shows on the outputs one cycle after the sampling edge. Bit i's gap begins at the sum of the earlier bit periods, counted from that first cycle. The closing gap follows the last bit. Done, and since-end = 0, fall on the cycle after the closing gap. The bench drives inputs on falling edges and works out, at each falling edge, the expected carrier, busy and done levels from that cycle's index. It then compares every cycle of each frame and the two cycles that follow it, including a frame that receives a strobe partway through.

// File: rtl/pef_pkg.sv
// Shared types for the pause-width frame encoder.
// Assumes: nothing beyond IEEE 1800-2017.
package pef_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BIT  = 2'd1,
        ST_TAIL = 2'd2
    } tx_state_e;
endpackage

// File: rtl/pef_shifter.sv
// Data shift register and remaining-bit counter.
// Loads the word and the clamped count on load_i, and shifts right on adv_i.
// Assumes: load_i and adv_i are never high together.
module pef_shifter #(
    parameter int MAX_BITS = 16,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                adv_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [CNT_W-1:0]    nbits_i,
    output logic                cur_bit_o,
    output logic                last_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BITS);

    logic [MAX_BITS-1:0] shreg;
    logic [CNT_W-1:0]    left;

    // Load on start, consume one bit per completed bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (load_i) begin
            shreg <= data_i;
            left  <= (nbits_i > MAX_CNT) ? MAX_CNT : nbits_i;
        end else if (adv_i) begin
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
        end
    end

    // The bit now on the line, and whether it is the final one.
    assign cur_bit_o = shreg[0];
    assign last_o    = (left == CNT_W'(1));
endmodule

// File: rtl/pef_ctrl.sv
// Frame sequencer: holds the state and the cycle count within a bit or the
// closing gap, and drives the carrier and handshake outputs.
// Assumes: PAUSE_CYC < ZERO_CYC, PAUSE_CYC < ONE_CYC, PAUSE_CYC >= 1.
module pef_ctrl
    import pef_pkg::*;
#(
    parameter int PAUSE_CYC = 20,
    parameter int ZERO_CYC  = 50,
    parameter int ONE_CYC   = 80,
    localparam int LONGEST  = (ONE_CYC > ZERO_CYC) ? ONE_CYC : ZERO_CYC,
    localparam int CYC_W    = $clog2(LONGEST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic count_zero_i,
    input  logic cur_bit_i,
    input  logic last_i,
    output logic load_o,
    output logic adv_o,
    output logic end_o,
    output logic carrier_o,
    output logic busy_o,
    output logic done_o
);
    localparam logic [CYC_W-1:0] PAUSE_LAST = CYC_W'(PAUSE_CYC - 1);
    localparam logic [CYC_W-1:0] PAUSE_LEN  = CYC_W'(PAUSE_CYC);
    localparam logic [CYC_W-1:0] ZERO_LAST  = CYC_W'(ZERO_CYC - 1);
    localparam logic [CYC_W-1:0] ONE_LAST   = CYC_W'(ONE_CYC - 1);

    tx_state_e        state;
    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] bit_last;

    // Last cycle index of the bit now being sent.
    assign bit_last = cur_bit_i ? ONE_LAST : ZERO_LAST;

    // Strobes for the shifter and the reference timer.
    assign load_o = (state == ST_IDLE) && start_i;
    assign adv_o  = (state == ST_BIT) && (cyc == bit_last);
    assign end_o  = (state == ST_TAIL) && (cyc == PAUSE_LAST);

    // Carrier is off during the opening gap of each bit and the closing gap.
    assign carrier_o = (state == ST_IDLE) || ((state == ST_BIT) && (cyc >= PAUSE_LEN));
    assign busy_o    = (state != ST_IDLE);

    // State, cycle counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cyc    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cyc <= '0;
                    if (start_i) state <= count_zero_i ? ST_TAIL : ST_BIT;
                end
                ST_BIT: begin
                    if (cyc == bit_last) begin
                        cyc <= '0;
                        if (last_i) state <= ST_TAIL;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cyc == PAUSE_LAST) begin
                        cyc    <= '0;
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pef_ref_timer.sv
// Elapsed-time counter referenced to the end of the last frame.
// Cleared at the frame end edge; counts up and holds at all ones.
// Assumes: clear_i is a single-cycle strobe.
module pef_ref_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [REF_W-1:0] count_o
);
    // Restart on clear, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_o <= '1;
        else if (clear_i)        count_o <= '0;
        else if (count_o != '1)  count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/rdr_pause_encoder.sv
// Top level of the pause-width reader frame encoder.
// Connects the sequencer, the data shifter and the since-end timer.
// Assumes: parameters meet PAUSE_CYC < ZERO_CYC and PAUSE_CYC < ONE_CYC.
module rdr_pause_encoder #(
    parameter int PAUSE_CYC = 20,
    parameter int ZERO_CYC  = 50,
    parameter int ONE_CYC   = 80,
    parameter int MAX_BITS  = 16,
    parameter int REF_W     = 16,
    localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [CNT_W-1:0]    nbits_i,
    output logic                carrier_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [REF_W-1:0]    since_end_o
);
    logic load, adv, frame_end, cur_bit, last_bit, count_zero;

    // A zero count skips straight to the closing gap.
    assign count_zero = (nbits_i == '0);

    pef_ctrl #(
        .PAUSE_CYC(PAUSE_CYC), .ZERO_CYC(ZERO_CYC), .ONE_CYC(ONE_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .count_zero_i(count_zero), .cur_bit_i(cur_bit), .last_i(last_bit),
        .load_o(load), .adv_o(adv), .end_o(frame_end),
        .carrier_o(carrier_o), .busy_o(busy_o), .done_o(done_o)
    );

    pef_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
        .data_i(data_i), .nbits_i(nbits_i),
        .cur_bit_o(cur_bit), .last_o(last_bit)
    );

    pef_ref_timer #(.REF_W(REF_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .clear_i(frame_end), .count_o(since_end_o)
    );
endmodule

// File: rtl/rdr_pause_encoder_chk.sv
// Property checker for rdr_pause_encoder, attached by bind.
// Assumes: observes top-level ports only.
module rdr_pause_encoder_chk #(
    parameter int PAUSE_CYC = 20,
    parameter int REF_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             carrier_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [REF_W-1:0] since_end_o
);
    localparam int RUN_W = $clog2(PAUSE_CYC + 2) + 1;
    logic [RUN_W-1:0] low_run;

    // Count consecutive carrier-off cycles before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!carrier_o) low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
        else                 low_run <= '0;
    end

    AST_PAUSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_o |-> (low_run < RUN_W'(PAUSE_CYC)));                        // R1
    AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> carrier_o);                                               // R7
    AST_START_OPENS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !carrier_o));                     // R7
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));                                    // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R8
    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && carrier_o && $past(busy_o) && !$past(carrier_o))); // R8
    AST_REF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_end_o == '0));                                      // R9
    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && $past(since_end_o) != '1 && $past(rst_n)) |->
            (since_end_o == $past(since_end_o) + 1'b1));                      // R9
endmodule

bind rdr_pause_encoder rdr_pause_encoder_chk #(
    .PAUSE_CYC(PAUSE_CYC), .REF_W(REF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .carrier_o(carrier_o),
    .busy_o(busy_o), .done_o(done_o), .since_end_o(since_end_o)
);

// File: tb/rdr_pause_encoder_tb.sv
// Self-checking bench: vector table of frames, then directed corner cases.
module rdr_pause_encoder_tb;
    localparam int P  = 3;
    localparam int T0 = 7;
    localparam int T1 = 11;
    localparam int MB = 16;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [4:0]  nbits_i = '0;
    logic carrier_o, busy_o, done_o;
    logic [RW-1:0] since_end_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rdr_pause_encoder #(
        .PAUSE_CYC(P), .ZERO_CYC(T0), .ONE_CYC(T1), .MAX_BITS(MB), .REF_W(RW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .nbits_i(nbits_i), .carrier_o(carrier_o), .busy_o(busy_o),
        .done_o(done_o), .since_end_o(since_end_o)
    );

    // Table entries: {nbits[4:0], data[15:0]}.
    localparam logic [20:0] VEC [6] = '{
        {5'd1,  16'h0001}, {5'd1,  16'h0000}, {5'd8,  16'h00A5},
        {5'd16, 16'hFFFF}, {5'd16, 16'h1234}, {5'd5,  16'hFFEA}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Send one frame and compare every cycle; optionally strobe start mid-frame.
    task automatic run_frame(input logic [15:0] d, input logic [4:0] n, input bit inject);
        int eff;
        int k;
        logic [2:0] act;
        logic [2:0] exp;
        eff = (n > 5'd16) ? 16 : int'(n);
        k = 0;
        @(negedge clk);
        data_i = d; nbits_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < eff; i++) begin
            int per;
            per = d[i] ? T1 : T0;
            for (int c = 0; c < per; c++) begin
                act = {carrier_o, busy_o, done_o};
                exp = {(c >= P), 1'b1, 1'b0};
                // R1 gap cycles, R2/R3 carrier-on cycles of an LSB-first bit
                check(act == exp, inject ? "R6" : ((c < P) ? "R1" : "R2 R3"), act, exp);
                if (inject && k == 1) begin
                    data_i = ~d; nbits_i = 5'd2; start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        for (int c = 0; c < P; c++) begin
            act = {carrier_o, busy_o, done_o};
            exp = 3'b010;
            check(act == exp, (eff == 0) ? "R5" : "R4", act, exp);
            start_i = 1'b0;
            @(negedge clk);
        end
        act = {carrier_o, busy_o, done_o};
        check(act == 3'b101, "R8", act, 3'b101);
        check(since_end_o == '0, "R9", since_end_o, 0);
        @(negedge clk);
        act = {carrier_o, busy_o, done_o};
        check(act == 3'b100, "R7 R8", act, 3'b100);
        check(since_end_o == RW'(1), "R9", since_end_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({carrier_o, busy_o, done_o} == 3'b100, "R10", {carrier_o, busy_o, done_o}, 3'b100);
        check(since_end_o == '1, "R10", since_end_o, 8'hFF);

        foreach (VEC[v]) run_frame(VEC[v][15:0], VEC[v][20:16], 1'b0);

        // R5 zero count: only the closing gap
        run_frame(16'hBEEF, 5'd0, 1'b0);
        // R5 count above 16 clamps to 16
        run_frame(16'h8001, 5'd20, 1'b0);
        // R6 strobe during a frame is ignored
        run_frame(16'h00C3, 5'd8, 1'b1);

        // R9 saturation after a long idle stretch
        repeat (300) @(negedge clk);
        check(since_end_o == '1, "R9", since_end_o, 8'hFF);
        check({carrier_o, busy_o} == 2'b10, "R7", {carrier_o, busy_o}, 2'b10);

        // R10 reset mid-frame returns to idle
        @(negedge clk);
        data_i = 16'h0F0F; nbits_i = 5'd8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check({carrier_o, busy_o, done_o} == 3'b100, "R10", {carrier_o, busy_o, done_o}, 3'b100);
        check(since_end_o == '1, "R10", since_end_o, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule